// File: doc/BRIEF.md
# Stereo I/Q Serial Link Master with DAC Source Select

This block is the serial-audio bus master of a receiver's baseband path. It divides the system clock into a bit clock and a word-select line. It sends each decimated complex sample as one stereo frame to a processor: the in-phase word goes in the left slot and the quadrature word in the right slot. Under the same frame timing it captures the processed audio that the processor returns on a serial input. It also drives a second serial data line toward an audio DAC.

The DAC line carries one of two sources, picked by a select input. One is the raw I/Q frame, identical to what the processor receives. The other is the returned audio. Samples arrive as a parallel I/Q pair with a one-cycle valid strobe. The block keeps the most recent pair and loads it into the outgoing frame at each frame start. If no new pair has come, the previous one is sent again.

Top module: `iq_serial_link`

## Requirements
- R1: While reset is high, and at the first clock after it falls, `bclk` is 0, `ws` is 1, and `sd_proc` and `sd_dac` are 0.
- R2: Each half period of `bclk` lasts exactly CLK_DIV system clocks. A frame spans 2*WORD_W bit-clock periods, so the gap between successive falling edges of `ws` is 4*WORD_W*CLK_DIV clocks.
- R3: `ws`, `sd_proc` and `sd_dac` change only where `bclk` falls. `ws` is low (left slot) for WORD_W bit-clock periods, then high (right slot) for WORD_W periods.
- R4: On `sd_proc`, each word is sent MSB first and starts one bit-clock period after the `ws` transition that opens its slot. The left slot carries `i_in` and the right slot carries `q_in`. The frame value is {I, Q}, with I in the upper half.
- R5: A frame carries the last pair accepted with `iq_valid` high before the cycle in which the frame starts. When several pairs arrive within one frame, only the last one is sent.
- R6: When no valid pair arrives during a frame, the next frame repeats the previous pair unchanged.
- R7: `sd_ret` is sampled on rising edges of `bclk` and assembled with the same slot layout as R4 (left word in the upper half of the frame).
- R8: With the DAC source set to I/Q (`dac_sel` = 0 at frame start), `sd_dac` carries the same frame as `sd_proc`. `dac_sel` never alters `sd_proc`.
- R9: With the DAC source set to returned audio (`dac_sel` = 1), a returned frame whose last bit arrives in the first bit slot of frame n is sent on `sd_dac` during frame n+1.
- R10: `dac_sel` is sampled only at frame start. A change in mid-frame leaves the current frame's source unchanged and takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | One-cycle strobe marking a new I/Q pair |
| i_in | input | WORD_W | In-phase sample word |
| q_in | input | WORD_W | Quadrature sample word |
| sd_ret | input | 1 | Serial returned-audio data from the processor |
| dac_sel | input | 1 | DAC source: 0 = raw I/Q, 1 = returned audio |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select: 0 = left slot, 1 = right slot |
| sd_proc | output | 1 | Serial I/Q data to the processor |
| sd_dac | output | 1 | Serial data to the DAC |

## Verification
A slot counter that is off by one shifts every decoded word by one bit, so the very first complete frame after reset decodes to a wrong value. A corrupted divider count shows up within one half period of `bclk` as a wrong phase length. A mis-latched sample holding register or source select shows up one frame after the stimulus, as a stale or wrong word pair on `sd_proc` or `sd_dac`. A receive path that loses alignment returns a bit-rotated audio frame on `sd_dac` two frames after the processor sends it.

// File: rtl/iqlink_pkg.sv
package iqlink_pkg;
  // Source of the DAC-side serial line
  typedef enum logic {
    SRC_IQ  = 1'b0,
    SRC_RET = 1'b1
  } dac_src_e;
endpackage

// File: rtl/iqlink_bitclk.sv
// Integer divider producing the bit clock and one-cycle edge strobes.
module iqlink_bitclk #(
  parameter int CLK_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic edge_w;

  generate
    if (CLK_DIV == 1) begin : g_direct
      assign edge_w = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign edge_w = (cnt_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk_o <= 1'b0;
    else if (edge_w) bclk_o <= ~bclk_o;
  end

  // strobes mark the cycle at whose end the bit clock toggles
  assign rise_o = edge_w & ~bclk_o;
  assign fall_o = edge_w & bclk_o;
endmodule

// File: rtl/iqlink_slotseq.sv
// Bit-slot counter and word-select generation, advanced on falling bit-clock edges.
module iqlink_slotseq #(
  parameter int WORD_W  = 16,
  localparam int FRAME_W = 2 * WORD_W,
  localparam int SLOT_W  = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_tick,
  output logic [SLOT_W-1:0] slot_o,
  output logic              ws_o,
  output logic              frame_start_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_W - 1);
  localparam logic [SLOT_W-1:0] RIGHT_SLOT = SLOT_W'(WORD_W);

  logic [SLOT_W-1:0] next_slot;

  assign next_slot     = (slot_o == LAST_SLOT) ? '0 : slot_o + 1'b1;
  assign frame_start_o = fall_tick & (slot_o == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o <= LAST_SLOT;
      ws_o   <= 1'b1;
    end else if (fall_tick) begin
      slot_o <= next_slot;
      ws_o   <= (next_slot >= RIGHT_SLOT);
    end
  end
endmodule

// File: rtl/iqlink_txser.sv
// Frame serializer: one bit per falling edge, MSB first, reload at frame start.
module iqlink_txser #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fall_tick,
  input  logic               frame_start,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sd_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      sd_o <= 1'b0;
    end else if (fall_tick) begin
      // the bit leaving now is the last bit of the old frame at frame start,
      // which gives the one-slot delay after the word-select edge
      sd_o <= sr_q[FRAME_W-1];
      if (frame_start) sr_q <= load_word;
      else             sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/iqlink_rxdes.sv
// Frame deserializer: samples on rising edges and publishes a complete frame
// at the rising edge of slot 0, when the delayed last bit has arrived.
module iqlink_rxdes #(
  parameter int FRAME_W = 32,
  localparam int SLOT_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise_tick,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               sd_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_next;

  assign sr_next = {sr_q[FRAME_W-2:0], sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      frame_o <= '0;
    end else if (rise_tick) begin
      sr_q <= sr_next;
      if (slot_i == '0) frame_o <= sr_next;
    end
  end
endmodule

// File: rtl/iq_serial_link.sv
module iq_serial_link
  import iqlink_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iq_valid,
  input  logic [WORD_W-1:0] i_in,
  input  logic [WORD_W-1:0] q_in,
  input  logic              sd_ret,
  input  logic              dac_sel,
  output logic              bclk,
  output logic              ws,
  output logic              sd_proc,
  output logic              sd_dac
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int SLOT_W  = $clog2(FRAME_W);

  logic              rise_w, fall_w, fstart_w;
  logic [SLOT_W-1:0] slot_w;
  logic [FRAME_W-1:0] iq_hold_q;
  logic [FRAME_W-1:0] ret_frame_w;
  logic [FRAME_W-1:0] dac_load_w;
  dac_src_e           src_w;

  iqlink_bitclk #(.CLK_DIV(CLK_DIV)) clk_i (
    .clk    (clk),
    .rst    (rst),
    .bclk_o (bclk),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  iqlink_slotseq #(.WORD_W(WORD_W)) seq_i (
    .clk           (clk),
    .rst           (rst),
    .fall_tick     (fall_w),
    .slot_o        (slot_w),
    .ws_o          (ws),
    .frame_start_o (fstart_w)
  );

  // latest offered pair, I in the upper half
  always_ff @(posedge clk) begin
    if (rst) iq_hold_q <= '0;
    else if (iq_valid) iq_hold_q <= {i_in, q_in};
  end

  iqlink_txser #(.FRAME_W(FRAME_W)) tx_proc_i (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_w),
    .frame_start (fstart_w),
    .load_word   (iq_hold_q),
    .sd_o        (sd_proc)
  );

  iqlink_rxdes #(.FRAME_W(FRAME_W)) rx_ret_i (
    .clk       (clk),
    .rst       (rst),
    .rise_tick (rise_w),
    .slot_i    (slot_w),
    .sd_i      (sd_ret),
    .frame_o   (ret_frame_w)
  );

  // source is taken only when the DAC serializer reloads (frame start)
  assign src_w      = dac_sel ? SRC_RET : SRC_IQ;
  assign dac_load_w = (src_w == SRC_RET) ? ret_frame_w : iq_hold_q;

  iqlink_txser #(.FRAME_W(FRAME_W)) tx_dac_i (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_w),
    .frame_start (fstart_w),
    .load_word   (dac_load_w),
    .sd_o        (sd_dac)
  );
endmodule

// File: rtl/iqlink_chk.sv
module iqlink_chk #(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 32
) (
  input logic clk,
  input logic rst,
  input logic bclk,
  input logic ws,
  input logic sd_proc,
  input logic sd_dac
);
  logic [15:0] half_cnt;
  logic [7:0]  fall_cnt;
  logic        ws_seen;

  // independent phase counter for the bit clock
  always_ff @(posedge clk) begin
    if (rst) half_cnt <= '0;
    else if (half_cnt == 16'(CLK_DIV - 1)) half_cnt <= '0;
    else half_cnt <= half_cnt + 1'b1;
  end

  // falling bit-clock edges since the last word-select change
  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      ws_seen  <= 1'b0;
    end else if (ws != $past(ws)) begin
      fall_cnt <= '0;
      ws_seen  <= 1'b1;
    end else if ($fell(bclk)) begin
      fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R2
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (half_cnt == 16'(CLK_DIV - 1)) |=> (bclk != $past(bclk)));

  // R2
  bclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (half_cnt != 16'(CLK_DIV - 1)) |=> $stable(bclk));

  // R3
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> $fell(bclk));

  // R3
  ws_slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ws) && ws_seen) |-> (fall_cnt == 8'(WORD_W - 1)));

  // R3
  proc_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_proc) |-> $fell(bclk));

  // R3
  dac_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_dac) |-> $fell(bclk));
endmodule

bind iq_serial_link iqlink_chk #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .bclk    (bclk),
  .ws      (ws),
  .sd_proc (sd_proc),
  .sd_dac  (sd_dac)
);

// File: tb/iq_serial_link_tb_top.sv
module iq_serial_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int CLK_DIV    = 2;
  localparam int FRAME_W    = 2 * WORD_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iq_valid = 1'b0;
  logic [WORD_W-1:0] i_in = '0;
  logic [WORD_W-1:0] q_in = '0;
  logic sd_ret = 1'b0;
  logic dac_sel = 1'b0;
  logic bclk, ws, sd_proc, sd_dac;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iq_serial_link #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst(rst), .iq_valid(iq_valid), .i_in(i_in), .q_in(q_in),
    .sd_ret(sd_ret), .dac_sel(dac_sel), .bclk(bclk), .ws(ws),
    .sd_proc(sd_proc), .sd_dac(sd_dac)
  );

  // receiver model of both output lines: decodes the last complete frame
  logic [FRAME_W-1:0] sh_p = '0, sh_d = '0, last_proc = '0, last_dac = '0;
  logic prev_ws_m = 1'b1;
  always @(posedge bclk) begin
    if (!ws && prev_ws_m) begin
      last_proc = {sh_p[FRAME_W-2:0], sd_proc};
      last_dac  = {sh_d[FRAME_W-2:0], sd_dac};
    end
    sh_p = {sh_p[FRAME_W-2:0], sd_proc};
    sh_d = {sh_d[FRAME_W-2:0], sd_dac};
    prev_ws_m = ws;
  end

  // processor model returning audio frames on sd_ret
  logic [FRAME_W-1:0] ret_next = '0, ret_sr = '0;
  logic prev_ws_p = 1'b1;
  always @(negedge bclk) begin
    #1;
    sd_ret = ret_sr[FRAME_W-1];
    if (!ws && prev_ws_p) ret_sr = ret_next;
    else ret_sr = {ret_sr[FRAME_W-2:0], 1'b0};
    prev_ws_p = ws;
  end

  task automatic chk(input string tag, input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic next_start();
    @(negedge ws); #1;
  endtask

  task automatic grab();
    @(posedge bclk); #1;
  endtask

  task automatic put_sample(input logic [WORD_W-1:0] iv, input logic [WORD_W-1:0] qv);
    @(negedge clk);
    iq_valid = 1'b1; i_in = iv; q_in = qv;
    @(negedge clk);
    iq_valid = 1'b0; i_in = '0; q_in = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, bclk, ws, sd_proc, sd_dac}, {28'd0, 1'b0, 1'b1, 1'b0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", {28'd0, bclk, ws, sd_proc, sd_dac}, {28'd0, 1'b0, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_timing();
    int n = 0;
    int t0, t1, t2;
    @(posedge bclk);
    forever begin
      @(negedge clk);
      if (!bclk) break;
      n++;
    end
    chk("R2 half period", 32'(n), 32'(CLK_DIV));
    next_start(); t0 = cyc;
    @(posedge ws); #1; t1 = cyc;
    next_start(); t2 = cyc;
    chk("R3 left slot length", 32'(t1 - t0), 32'(2 * WORD_W * CLK_DIV));
    chk("R2 frame length", 32'(t2 - t0), 32'(4 * WORD_W * CLK_DIV));
  endtask

  task automatic t_iq(input logic [WORD_W-1:0] iv, input logic [WORD_W-1:0] qv);
    next_start();
    put_sample(iv, qv);
    next_start(); next_start(); grab();
    chk("R4 proc frame I/Q layout", last_proc, {iv, qv});
  endtask

  task automatic t_latest();
    next_start();
    put_sample(16'h1111, 16'h2222);
    put_sample(16'hBEEF, 16'h0F0F);
    next_start(); next_start(); grab();
    chk("R5 latest sample wins", last_proc, {16'hBEEF, 16'h0F0F});
    next_start(); grab();
    chk("R6 repeat without valid", last_proc, {16'hBEEF, 16'h0F0F});
    next_start(); grab();
    chk("R6 repeat second frame", last_proc, {16'hBEEF, 16'h0F0F});
  endtask

  task automatic t_dac_iq();
    dac_sel = 1'b0;
    next_start();
    put_sample(16'h8001, 16'h7FFE);
    next_start(); next_start(); grab();
    chk("R8 dac equals proc", last_dac, {16'h8001, 16'h7FFE});
    chk("R8 proc frame", last_proc, {16'h8001, 16'h7FFE});
  endtask

  task automatic t_audio();
    dac_sel = 1'b1;
    ret_next = 32'hC0DE_5A5A;
    repeat (4) next_start();
    grab(); ret_next = 32'hA5A5_0001;
    next_start(); grab(); ret_next = 32'h8000_FFFE;
    next_start(); grab();
    chk("R9 latency old frame", last_dac, 32'hC0DE_5A5A);
    next_start(); grab();
    chk("R9 latency still old", last_dac, 32'hC0DE_5A5A);
    next_start(); grab();
    chk("R7 R9 first returned frame", last_dac, 32'hA5A5_0001);
    next_start(); grab();
    chk("R7 R9 second returned frame", last_dac, 32'h8000_FFFE);
    chk("R8 sel does not alter proc", last_proc, {16'h8001, 16'h7FFE});
  endtask

  task automatic t_sel_switch();
    dac_sel = 1'b0;
    ret_next = 32'h1357_9BDF;
    next_start();
    put_sample(16'h0246, 16'h8ACE);
    repeat (4) next_start();
    grab(); dac_sel = 1'b1;
    next_start(); grab();
    chk("R10 mid-frame switch keeps IQ", last_dac, {16'h0246, 16'h8ACE});
    next_start(); grab();
    chk("R10 switch applies next frame", last_dac, 32'h1357_9BDF);
    grab(); dac_sel = 1'b0;
    next_start(); grab();
    chk("R10 switch back keeps audio", last_dac, 32'h1357_9BDF);
    next_start(); grab();
    chk("R10 back to IQ", last_dac, {16'h0246, 16'h8ACE});
  endtask

  initial begin
    t_reset();
    t_timing();
    t_iq(16'h1234, 16'hABCD);
    t_iq(16'hFFFF, 16'h0000);
    t_latest();
    t_dac_iq();
    t_audio();
    t_sel_switch();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule